// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one pointer movement sample into a five-byte packet and hands the bytes out one at a time. A sample carries a signed horizontal delta, a signed vertical delta and the states of three buttons. The first byte is a sync byte with the button states in its low bits, written active-low. The second byte is the horizontal delta, clipped to a symmetric 8-bit range. The third byte is the vertical delta with its sign flipped and clipped to the same range. Two zero bytes close every packet.

Both sides use a valid/ready handshake. The sample port takes a sample only while the encoder is idle, so `smp_ready` is low for the whole time a packet is in flight. A sample offered during that time waits, and the producer must hold it stable until it is taken. The byte port follows the usual back-pressure rule. Once `out_valid` is high, `out_data` and `out_valid` stay fixed until the consumer raises `out_ready`, and each cycle with both high moves one byte. The `busy` flag tells the surrounding logic when a packet is being emitted.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset `busy` and `out_valid` are 0 and `smp_ready` is 1.
- R2: A sample is taken only in a cycle where `smp_ready` is high, which is exactly when `busy` is low. A sample offered while busy has no effect on the bytes of the packet in flight.
- R3: Byte 0 is 0x87 with bits cleared for pressed buttons. `smp_btn[2]` (left) clears bit 2, `smp_btn[1]` (middle) clears bit 1 and `smp_btn[0]` (right) clears bit 0. A button input of 1 means pressed.
- R4: Byte 1 is the horizontal delta as 8-bit two's complement, clipped to -127..+127. Any 16-bit input value is handled, and 0x80 never appears.
- R5: Byte 2 is the negated vertical delta, clipped to -127..+127. An input of -32768 gives +127.
- R6: Bytes 3 and 4 are always 0x00.
- R7: Bytes leave in order 0 to 4, one per cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R8: `busy` and `out_valid` rise in the cycle after a sample is taken. They fall in the cycle after byte 4 is taken.
- R9: A new sample can be taken in the cycle right after byte 4 is taken. Its byte 0 then appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | A movement sample is offered |
| smp_ready | output | 1 | The encoder will take the offered sample |
| smp_dx | input | 16 | Horizontal delta, signed |
| smp_dy | input | 16 | Vertical delta, signed |
| smp_btn | input | 3 | Button states [2]=left [1]=middle [0]=right, 1 = pressed |
| out_valid | output | 1 | `out_data` holds a packet byte |
| out_ready | input | 1 | The consumer takes the byte |
| out_data | output | 8 | Packet byte |
| busy | output | 1 | A packet is being emitted |

## Verification
The assertions take for granted that the producer holds `smp_valid` and the sample fields steady until the handshake completes. They also assume that `out_ready` may change in any cycle with no link to `out_valid`. The bench changes every input half a cycle away from the rising edge. It keeps a sample offered across several busy cycles, and it stalls the consumer mid-packet so the hold rule and the ignore rule are both tested. Delta values cover the whole 16-bit range, including both extremes whose sign flip does not fit in 16 bits.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int unsigned MPE_BYTE_W   = 8;
  localparam int unsigned MPE_HEAD_N   = 3;
  localparam logic [7:0]  MPE_SYNC_TOP = 8'h80;
  typedef enum logic [1:0] {AXIS_X = 2'd0, AXIS_Y = 2'd1} axis_e;
endpackage

// File: rtl/mpe_sat.sv
module mpe_sat #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned LIM   = 127,
  parameter bit          NEG   = 1'b0
) (
  input  logic [IN_W-1:0]  d_in,
  output logic [OUT_W-1:0] d_out
);
  localparam int unsigned EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] HI = EXT_W'(LIM);
  localparam logic signed [EXT_W-1:0] LO = -HI;

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] val;

  always_comb begin
    ext = {d_in[IN_W-1], d_in};
    val = NEG ? -ext : ext;
    if (val > HI)      d_out = HI[OUT_W-1:0];
    else if (val < LO) d_out = LO[OUT_W-1:0];
    else               d_out = val[OUT_W-1:0];
  end
endmodule

// File: rtl/mpe_hdr.sv
module mpe_hdr #(
  parameter int unsigned BTN_N  = 3,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BTN_N-1:0]  btn,
  output logic [BYTE_W-1:0] hdr
);
  import mpe_pkg::*;
  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    if (b < BTN_N) begin : g_btn
      assign hdr[b] = ~btn[b];
    end else if (b < 3) begin : g_fill
      assign hdr[b] = 1'b1;
    end else begin : g_sync
      assign hdr[b] = MPE_SYNC_TOP[b];
    end
  end
endmodule

// File: rtl/mpe_seq.sv
module mpe_seq #(
  parameter int unsigned PKT_LEN = 5,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned HEAD_N  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [HEAD_N*BYTE_W-1:0] head,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [BYTE_W-1:0]        out_data,
  output logic                     busy
);
  localparam int unsigned IDX_W = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_LEN - 1);

  logic [BYTE_W-1:0] pkt_q [PKT_LEN];
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              take;

  assign take = busy_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (take) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < PKT_LEN; g++) begin : g_slot
    if (g < HEAD_N) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pkt_q[g] <= '0;
        else if (load) pkt_q[g] <= head[g*BYTE_W +: BYTE_W];
      end
    end else begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pkt_q[g] <= '0;
        else if (load) pkt_q[g] <= '0;
      end
    end
  end

  assign out_data  = pkt_q[idx_q];
  assign out_valid = busy_q;
  assign busy      = busy_q;
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc #(
  parameter int unsigned DELTA_W = 16,
  parameter int unsigned BTN_N   = 3,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PKT_LEN = 5,
  parameter int unsigned SAT_LIM = 127
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [DELTA_W-1:0] smp_dx,
  input  logic [DELTA_W-1:0] smp_dy,
  input  logic [BTN_N-1:0]   smp_btn,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               busy
);
  import mpe_pkg::*;
  localparam int unsigned AXES = 2;

  logic [DELTA_W-1:0]       delta [AXES];
  logic [BYTE_W-1:0]        clip  [AXES];
  logic [BYTE_W-1:0]        hdr_b;
  logic [MPE_HEAD_N*BYTE_W-1:0] head;
  logic                     load;

  assign delta[AXIS_X] = smp_dx;
  assign delta[AXIS_Y] = smp_dy;

  mpe_hdr #(.BTN_N(BTN_N), .BYTE_W(BYTE_W)) u_hdr (
    .btn (smp_btn),
    .hdr (hdr_b)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    mpe_sat #(
      .IN_W  (DELTA_W),
      .OUT_W (BYTE_W),
      .LIM   (SAT_LIM),
      .NEG   (a == int'(AXIS_Y))
    ) u_sat (
      .d_in  (delta[a]),
      .d_out (clip[a])
    );
  end

  assign head      = {clip[AXIS_Y], clip[AXIS_X], hdr_b};
  assign smp_ready = !busy;
  assign load      = smp_valid && smp_ready;

  mpe_seq #(
    .PKT_LEN (PKT_LEN),
    .BYTE_W  (BYTE_W),
    .HEAD_N  (MPE_HEAD_N)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .head      (head),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .busy      (busy)
  );
endmodule

// File: rtl/mpe_chk.sv
module mpe_chk #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned PKT_LEN = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_data,
  input logic              busy
);
  localparam int unsigned CW = $clog2(PKT_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (smp_valid && smp_ready) cnt <= '0;
    else if (out_valid && out_ready) cnt <= cnt + 1'b1;
  end

  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !smp_ready); // R2
  AST_SYNC_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt == 0) |-> (out_data[7:3] == 5'b10000)); // R3
  AST_X_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt == 1) |-> (out_data != 8'h80)); // R4
  AST_Y_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt == 2) |-> (out_data != 8'h80)); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt >= 3) |-> (out_data == '0)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(smp_valid && smp_ready)); // R8
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(out_valid && out_ready) && $past(cnt) == CW'(PKT_LEN - 1))); // R8
endmodule

bind mouse_pkt_enc mpe_chk #(.BYTE_W(BYTE_W), .PKT_LEN(PKT_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .busy      (busy)
);

// File: tb/mouse_pkt_enc_bench.sv
module mouse_pkt_enc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_dx = '0;
  logic [15:0] smp_dy = '0;
  logic [2:0]  smp_btn = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mouse_pkt_enc u_mouse_pkt_enc (
    .clk, .rst_n, .smp_valid, .smp_ready, .smp_dx, .smp_dy, .smp_btn,
    .out_valid, .out_ready, .out_data, .busy
  );

  // {btn, dx, dy, byte0, byte1, byte2}
  localparam int NV = 10;
  localparam logic [58:0] VEC [NV] = '{
    {3'b000, 16'h0000, 16'h0000, 8'h87, 8'h00, 8'h00},
    {3'b100, 16'h0005, 16'h0003, 8'h83, 8'h05, 8'hFD},
    {3'b010, 16'hFFFB, 16'hFFFD, 8'h85, 8'hFB, 8'h03},
    {3'b001, 16'h007F, 16'hFF81, 8'h86, 8'h7F, 8'h7F},
    {3'b111, 16'h0080, 16'h0080, 8'h80, 8'h7F, 8'h81},
    {3'b011, 16'hFF80, 16'hFF80, 8'h84, 8'h81, 8'h7F},
    {3'b101, 16'h7FFF, 16'h8000, 8'h82, 8'h7F, 8'h7F},
    {3'b110, 16'h8000, 16'h7FFF, 8'h81, 8'h81, 8'h81},
    {3'b000, 16'hFF81, 16'h007F, 8'h87, 8'h81, 8'h81},
    {3'b000, 16'h0001, 16'hFFFF, 8'h87, 8'h01, 8'h01}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [2:0] b, input logic [15:0] dx, input logic [15:0] dy);
    smp_btn = b; smp_dx = dx; smp_dy = dy; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R8 busy after take", 16'(busy), 16'd1);
  endtask

  task automatic drain(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] exp [5];
    exp[0] = b0; exp[1] = b1; exp[2] = b2; exp[3] = 8'h00; exp[4] = 8'h00;
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk("R7 valid", 16'(out_valid), 16'd1);
      if (k == 0)      chk("R3 byte0", 16'(out_data), 16'(exp[k]));
      else if (k == 1) chk("R4 byte1", 16'(out_data), 16'(exp[k]));
      else if (k == 2) chk("R5 byte2", 16'(out_data), 16'(exp[k]));
      else             chk("R6 pad",   16'(out_data), 16'(exp[k]));
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R8 busy low after byte4", 16'(busy), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", 16'(busy), 16'd0);
    chk("R1 out_valid", 16'(out_valid), 16'd0);
    chk("R1 smp_ready", 16'(smp_ready), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      offer(VEC[v][58:56], VEC[v][55:40], VEC[v][39:24]);
      drain(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R7 stall and R2 ignore while busy
    offer(3'b100, 16'h0010, 16'h0020);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    smp_btn = 3'b000; smp_dx = 16'h0001; smp_dy = 16'h0001; smp_valid = 1'b1;
    for (int s = 0; s < 4; s++) begin
      chk("R2 ready low while busy", 16'(smp_ready), 16'd0);
      chk("R7 held byte1", 16'(out_data), 16'h0010);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    out_ready = 1'b1;
    chk("R7 byte1 after stall", 16'(out_data), 16'h0010);
    @(negedge clk);
    chk("R2 byte2 unchanged", 16'(out_data), 16'h00E0);
    @(negedge clk);
    chk("R6 pad", 16'(out_data), 16'h0000);
    @(negedge clk);
    // R9 back-to-back: offer next sample during last byte
    smp_btn = 3'b001; smp_dx = 16'hFFF0; smp_dy = 16'h0200; smp_valid = 1'b1;
    chk("R6 pad last", 16'(out_data), 16'h0000);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 ready after byte4", 16'(smp_ready), 16'd1);
    chk("R9 idle after byte4", 16'(busy), 16'd0);
    @(negedge clk);
    smp_valid = 1'b0;
    chk("R9 new packet busy", 16'(busy), 16'd1);
    drain(8'h86, 8'hF0, 8'h81);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule